// File: doc/BRIEF.md
# Cached-Head Ring Buffer Controller

This block is a bounded first-in first-out buffer. The oldest stored value never sits in the storage ring. It is kept in a head register, so the output port can present it without a memory access. Every younger value is placed in a circular set of storage cells, and there are capacity minus one of them. Values enter through a valid/ready input port and leave through a valid/ready output port.

The controller reaches the ring only through indexed transactions. It raises a write or read request with a cell index and holds it until the ring acknowledges. A read acknowledge returns the cell contents. The controller keeps a write index, a read index and an element count. Full and empty both leave the two indices equal, so the count alone decides whether the buffer can accept or offer.

A ring transaction occupies the controller for two cycles. During that time the controller neither accepts nor offers data. Pushing into an empty buffer, or popping the last element, touches only the head register and costs no stall.

Top module: `cring_fifo`

## Requirements
- R1: The buffer holds at most CAP values (default 4). Once CAP values are held and no ring transaction is pending, `in_ready` is low.
- R2: Values leave on `out_data` in the order they were accepted, with none lost and none duplicated.
- R3: `in_ready` is high only while fewer than CAP values are held. `out_valid` is high only while at least one value is held.
- R4: A value accepted while the buffer is empty is placed straight into the head register. In the cycle after acceptance, `out_valid` is high with that value and `in_ready` is high again.
- R5: A value accepted while the buffer is non-empty is written into the ring by a request held until acknowledge. `in_ready` and `out_valid` are low for exactly the two cycles after the accepting edge.
- R6: A value delivered while more than one is held causes a ring read at the read index. `in_ready` and `out_valid` are low for the two cycles after the delivering edge. After that, the next-oldest value is presented.
- R7: Delivering the last held value empties the buffer with no ring access. In the next cycle `in_ready` is high and `out_valid` is low.
- R8: After a synchronous active-low reset, `out_valid` is low and `in_ready` is high. The count is 0 and both ring indices are 1.
- R9: Ring indices run 1 to CAP-1 and advance from CAP-1 back to 1. Whenever the ring holds no entries or all CAP-1 entries, the two indices are equal.
- R10: If the output handshake completes in a cycle, the input is not accepted in that cycle: `in_ready` is low whenever `out_valid` and `out_ready` are both high.
- R11: While a ring request is outstanding, `in_ready` and `out_valid` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers `in_data` |
| in_data | input | DW | Value to store |
| in_ready | output | 1 | Buffer accepts a value this cycle |
| out_valid | output | 1 | Head value is offered |
| out_data | output | DW | Oldest held value |
| out_ready | input | 1 | Consumer takes the head value |

## Verification
The bench keeps a cycle-accurate model of occupancy and stall timing, and compares both handshake outputs with it in every cycle. It sweeps a grid of producer and consumer duty cycles so that the indices wrap many times at every fill level.

The corner cases get directed sequences:
- Pushing into an empty buffer. A design that wrongly used the ring here would stall two cycles.
- Popping the last element. A design that read the ring here would stall and load a stale value.
- Hitting capacity. A design with a wrong count would accept a fifth value or deadlock.
- Offering input and output together. A design that accepted both at once would break R10 and corrupt the count.

A design that compared indices instead of keeping a count would treat full as empty and lose the whole contents. The ordering check catches that.

// File: rtl/cring_pkg.sv
// Package: shared types for the cached-head ring buffer.
// Assumes: nothing; holds only the controller state encoding.
package cring_pkg;

    // Controller phases: idle, waiting for a write ack, waiting for a read ack
    typedef enum logic [1:0] {
        CTL_IDLE    = 2'd0,
        CTL_WR_WAIT = 2'd1,
        CTL_RD_WAIT = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/cring_cell.sv
// Module: cring_cell
// One storage cell of the ring. It owns a fixed index CELL_ID and
// updates its value only when a write strobe carries that index.
// It drives its value onto its read output when the read index
// matches, and zero otherwise, so the parent can OR all cells together.
// Assumes: the contents after reset do not matter (no reset on the value).
module cring_cell #(
    parameter int DW      = 2,
    parameter int IDXW    = 2,
    parameter int CELL_ID = 1
) (
    input  logic            clk,
    input  logic            wr_go,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [DW-1:0]   rd_val
);

    localparam logic [IDXW-1:0] MY_IDX = IDXW'(CELL_ID);

    logic [DW-1:0] val_q;

    // Capture the write data when a strobe addresses this cell
    always_ff @(posedge clk) begin
        if (wr_go && (wr_idx == MY_IDX)) begin
            val_q <= wr_data;
        end
    end

    // Respond to a read only when addressed, else contribute zero
    always_comb begin
        rd_val = (rd_idx == MY_IDX) ? val_q : '0;
    end

endmodule

// File: rtl/cring_store.sv
// Module: cring_store
// The ring of CAP-1 cells behind an indexed request/acknowledge port.
// A request seen with no ack pending is served on the next edge. The
// ack goes high for one cycle. A read returns the addressed cell's
// value together with its ack.
// Assumes: the requester holds the request, index and data stable
// until it sees the ack, and then drops the request.
module cring_store #(
    parameter int CAP = 4,
    parameter int DW  = 2,
    parameter int IDXW = (CAP > 2) ? $clog2(CAP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    output logic            wr_ack,
    input  logic            rd_req,
    input  logic [IDXW-1:0] rd_idx,
    output logic            rd_ack,
    output logic [DW-1:0]   rd_data
);

    localparam int RING = CAP - 1;

    logic            wr_ack_q;
    logic            rd_ack_q;
    logic [DW-1:0]   rd_data_q;
    logic            wr_go;
    logic            rd_go;
    logic [DW-1:0]   cell_rd [RING];
    logic [DW-1:0]   rd_mux;

    // A request counts once: only while its ack is not yet showing
    always_comb begin
        wr_go = wr_req && !wr_ack_q;
        rd_go = rd_req && !rd_ack_q;
    end

    // One cell per ring slot, indexed from 1
    for (genvar g = 0; g < RING; g++) begin : g_cell
        cring_cell #(
            .DW     (DW),
            .IDXW   (IDXW),
            .CELL_ID(g + 1)
        ) u_cell (
            .clk    (clk),
            .wr_go  (wr_go),
            .wr_idx (wr_idx),
            .wr_data(wr_data),
            .rd_idx (rd_idx),
            .rd_val (cell_rd[g])
        );
    end

    // Merge cell responses; only the addressed cell is nonzero
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < RING; k++) begin
            rd_mux = rd_mux | cell_rd[k];
        end
    end

    // Acknowledge each new request one cycle later; capture read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ack_q  <= 1'b0;
            rd_ack_q  <= 1'b0;
            rd_data_q <= '0;
        end else begin
            wr_ack_q <= wr_go;
            rd_ack_q <= rd_go;
            if (rd_go) begin
                rd_data_q <= rd_mux;
            end
        end
    end

    assign wr_ack  = wr_ack_q;
    assign rd_ack  = rd_ack_q;
    assign rd_data = rd_data_q;

endmodule

// File: rtl/cring_ctrl.sv
// Module: cring_ctrl
// Buffer controller. It holds the head value in a cache register, an
// element count, and write (top) and read (bottom) ring indices. Input
// and output use valid/ready. Anything beyond the head goes through
// the ring's indexed request/acknowledge port. While a ring request
// is open, both handshakes are closed. When both sides are offered in
// the same cycle, the output side wins.
// Assumes: CAP >= 2; the ring acknowledges every request eventually.
module cring_ctrl
    import cring_pkg::*;
#(
    parameter int CAP  = 4,
    parameter int DW   = 2,
    parameter int IDXW = (CAP > 2) ? $clog2(CAP) : 1,
    parameter int CNTW = $clog2(CAP + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_data,
    output logic            in_ready,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    input  logic            out_ready,
    output logic            wr_req,
    output logic [IDXW-1:0] wr_idx,
    output logic [DW-1:0]   wr_data,
    input  logic            wr_ack,
    output logic            rd_req,
    output logic [IDXW-1:0] rd_idx,
    input  logic            rd_ack,
    input  logic [DW-1:0]   rd_data,
    output logic [CNTW-1:0] size_o,
    output logic [IDXW-1:0] top_o,
    output logic [IDXW-1:0] bot_o
);

    localparam int              RING     = CAP - 1;
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(CAP);
    localparam logic [CNTW-1:0] CNT_ONE  = CNTW'(1);
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(RING);
    localparam logic [IDXW-1:0] IDX_ONE  = IDXW'(1);

    ctl_state_e      state_q;
    logic [DW-1:0]   cache_q;
    logic [CNTW-1:0] size_q;
    logic [IDXW-1:0] top_q;
    logic [IDXW-1:0] bot_q;
    logic            wr_req_q;
    logic            rd_req_q;
    logic [IDXW-1:0] wr_idx_q;
    logic [IDXW-1:0] rd_idx_q;
    logic [DW-1:0]   wr_data_q;
    logic            idle;
    logic            out_fire;
    logic            in_fire;

    // Next ring index, wrapping from the last cell back to cell 1
    function automatic logic [IDXW-1:0] idx_next(input logic [IDXW-1:0] i);
        idx_next = (i == IDX_LAST) ? IDX_ONE : i + IDX_ONE;
    endfunction

    // Handshake gating: idle only, count-based, output has priority
    always_comb begin
        idle      = (state_q == CTL_IDLE);
        out_valid = idle && (size_q != '0);
        out_fire  = out_valid && out_ready;
        in_ready  = idle && (size_q < CNT_FULL) && !out_fire;
        in_fire   = in_valid && in_ready;
    end

    // Main sequencer: handshakes, ring transactions, count and indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= CTL_IDLE;
            cache_q   <= '0;
            size_q    <= '0;
            top_q     <= IDX_ONE;
            bot_q     <= IDX_ONE;
            wr_req_q  <= 1'b0;
            rd_req_q  <= 1'b0;
            wr_idx_q  <= IDX_ONE;
            rd_idx_q  <= IDX_ONE;
            wr_data_q <= '0;
        end else begin
            unique case (state_q)
                CTL_IDLE: begin
                    if (out_fire) begin
                        if (size_q == CNT_ONE) begin
                            size_q <= '0;
                        end else begin
                            rd_req_q <= 1'b1;
                            rd_idx_q <= bot_q;
                            state_q  <= CTL_RD_WAIT;
                        end
                    end else if (in_fire) begin
                        if (size_q == '0) begin
                            cache_q <= in_data;
                            size_q  <= CNT_ONE;
                        end else begin
                            wr_req_q  <= 1'b1;
                            wr_idx_q  <= top_q;
                            wr_data_q <= in_data;
                            state_q   <= CTL_WR_WAIT;
                        end
                    end
                end
                CTL_WR_WAIT: begin
                    if (wr_ack) begin
                        wr_req_q <= 1'b0;
                        size_q   <= size_q + CNT_ONE;
                        top_q    <= idx_next(top_q);
                        state_q  <= CTL_IDLE;
                    end
                end
                CTL_RD_WAIT: begin
                    if (rd_ack) begin
                        rd_req_q <= 1'b0;
                        cache_q  <= rd_data;
                        size_q   <= size_q - CNT_ONE;
                        bot_q    <= idx_next(bot_q);
                        state_q  <= CTL_IDLE;
                    end
                end
                default: begin
                    state_q <= CTL_IDLE;
                end
            endcase
        end
    end

    assign out_data = cache_q;
    assign wr_req   = wr_req_q;
    assign wr_idx   = wr_idx_q;
    assign wr_data  = wr_data_q;
    assign rd_req   = rd_req_q;
    assign rd_idx   = rd_idx_q;
    assign size_o   = size_q;
    assign top_o    = top_q;
    assign bot_o    = bot_q;

endmodule

// File: rtl/cring_fifo.sv
// Module: cring_fifo (top)
// Bounded FIFO of CAP values of DW bits. It joins the controller
// (head cache, count, indices) to the ring of CAP-1 cells over an
// internal indexed request/acknowledge link.
// Assumes: CAP >= 2; synchronous active-low reset.
module cring_fifo #(
    parameter int CAP = 4,
    parameter int DW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready
);

    localparam int IDXW = (CAP > 2) ? $clog2(CAP) : 1;
    localparam int CNTW = $clog2(CAP + 1);

    logic            wr_req;
    logic [IDXW-1:0] wr_idx;
    logic [DW-1:0]   wr_data;
    logic            wr_ack;
    logic            rd_req;
    logic [IDXW-1:0] rd_idx;
    logic            rd_ack;
    logic [DW-1:0]   rd_data;
    logic [CNTW-1:0] size_w;
    logic [IDXW-1:0] top_w;
    logic [IDXW-1:0] bot_w;

    // Controller: handshakes, head cache, count and indices
    cring_ctrl #(
        .CAP (CAP),
        .DW  (DW),
        .IDXW(IDXW),
        .CNTW(CNTW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_ready(out_ready),
        .wr_req   (wr_req),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .wr_ack   (wr_ack),
        .rd_req   (rd_req),
        .rd_idx   (rd_idx),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .size_o   (size_w),
        .top_o    (top_w),
        .bot_o    (bot_w)
    );

    // Ring of cells behind the request/acknowledge link
    cring_store #(
        .CAP (CAP),
        .DW  (DW),
        .IDXW(IDXW)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_req),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .wr_ack (wr_ack),
        .rd_req (rd_req),
        .rd_idx (rd_idx),
        .rd_ack (rd_ack),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/cring_fifo_checker.sv
// Module: cring_fifo_checker
// Temporal checks on the buffer. It is bound into cring_fifo and reads
// the handshake ports, the ring link and the controller's count and
// indices.
// Assumes: the same parameters as the bound instance.
module cring_fifo_checker #(
    parameter int CAP  = 4,
    parameter int IDXW = 2,
    parameter int CNTW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic            wr_req,
    input logic            wr_ack,
    input logic            rd_req,
    input logic            rd_ack,
    input logic [CNTW-1:0] size,
    input logic [IDXW-1:0] top_idx,
    input logic [IDXW-1:0] bot_idx
);

    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(CAP);
    localparam logic [CNTW-1:0] CNT_ONE  = CNTW'(1);
    localparam logic [IDXW-1:0] IDX_ONE  = IDXW'(1);

    logic after_rst_q;

    // Remember that the previous edge was under reset
    always_ff @(posedge clk) begin
        after_rst_q <= !rst_n;
    end

    assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst_q |-> (size == '0) && (top_idx == IDX_ONE) && (bot_idx == IDX_ONE));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (size < CNT_FULL));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (size != '0));

    assert_busy_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req || rd_req) |-> (!in_ready && !out_valid));

    assert_wr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);

    assert_wr_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> (size == $past(size) + CNT_ONE));

    assert_rd_shrink_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> (size == $past(size) - CNT_ONE));

    assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (size == '0)) |=> ((size == CNT_ONE) && !wr_req));

    assert_last_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (size == CNT_ONE)) |=> ((size == '0) && !rd_req));

    assert_ends_meet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && !rd_req && ((size <= CNT_ONE) || (size == CNT_FULL)))
            |-> (top_idx == bot_idx));

    assert_out_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> !in_ready);

endmodule

bind cring_fifo cring_fifo_checker #(
    .CAP (CAP),
    .IDXW(IDXW),
    .CNTW(CNTW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .wr_req   (wr_req),
    .wr_ack   (wr_ack),
    .rd_req   (rd_req),
    .rd_ack   (rd_ack),
    .size     (size_w),
    .top_idx  (top_w),
    .bot_idx  (bot_w)
);

// File: tb/cring_fifo_bench.sv
// Bench for cring_fifo. A queue model plus a stall counter predicts
// in_ready, out_valid and out_data in every cycle. Inputs are driven at
// the falling edge and the outputs are sampled 1 ns later.
module cring_fifo_bench;

    localparam int CAP = 4;
    localparam int DW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ready = 1'b0;

    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;
    logic [DW-1:0] model_q[$];
    int            busy = 0;

    always #5 clk = ~clk;

    cring_fifo #(.CAP(CAP), .DW(DW)) u_cring_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_ready(out_ready)
    );

    task automatic check_bit(input string tag, input string what,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare with the model, advance the model, clock
    task automatic step(input logic iv, input logic [DW-1:0] id,
                        input logic ordy, input string tag);
        logic exp_ov;
        logic exp_ir;
        logic fire_out;
        logic fire_in;
        int   n;
        in_valid  = iv;
        in_data   = id;
        out_ready = ordy;
        #1;
        n        = model_q.size();
        exp_ov   = (busy == 0) && (n > 0);
        fire_out = exp_ov && ordy;
        exp_ir   = (busy == 0) && (n < CAP) && !fire_out;
        fire_in  = exp_ir && iv;
        check_bit(tag, "out_valid", out_valid, exp_ov);
        check_bit(tag, "in_ready", in_ready, exp_ir);
        if (exp_ov && out_valid) begin
            checks++;
            if (out_data !== model_q[0]) begin
                errors++;
                $display("FAIL %s out_data actual=%0d expected=%0d", tag, out_data, model_q[0]);
            end
        end
        if (fire_out) begin
            void'(model_q.pop_front());
            busy = (n > 1) ? 2 : 0;
        end else if (fire_in) begin
            model_q.push_back(id);
            busy = (n > 0) ? 2 : 0;
        end else if (busy > 0) begin
            busy--;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset state at the ports
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_bit("R8", "in_ready after reset", in_ready, 1'b1);
        check_bit("R8", "out_valid after reset", out_valid, 1'b0);
        @(negedge clk);

        // R4: push into empty goes to the head with no stall
        step(1'b1, 2'd2, 1'b0, "R4");
        step(1'b0, 2'd0, 1'b0, "R4");

        // R5: push into non-empty stalls for two cycles
        step(1'b1, 2'd1, 1'b0, "R5");
        step(1'b0, 2'd0, 1'b0, "R5");
        step(1'b0, 2'd0, 1'b0, "R5");
        step(1'b0, 2'd0, 1'b0, "R5");

        // R1: fill to capacity, then input must be refused
        for (int k = 0; k < 6; k++) step(1'b1, DW'(k), 1'b0, "R1");
        for (int k = 0; k < 3; k++) step(1'b1, 2'd3, 1'b0, "R1");

        // R10: offer both sides; the output wins
        step(1'b1, 2'd0, 1'b1, "R10");
        step(1'b1, 2'd1, 1'b0, "R10");
        step(1'b1, 2'd1, 1'b1, "R10");
        for (int k = 0; k < 3; k++) step(1'b0, 2'd0, 1'b0, "R10");

        // R6 then R7: drain, the last pop has no stall
        for (int k = 0; k < 14; k++) step(1'b0, 2'd0, 1'b1, (model_q.size() > 1) ? "R6" : "R7");
        step(1'b0, 2'd0, 1'b0, "R7");

        // R2 and R9: sweep producer and consumer duty cycles, many wraps
        for (int pi = 0; pi <= 4; pi++) begin
            for (int po = 0; po <= 4; po++) begin
                for (int c = 0; c < 200; c++) begin
                    step(($urandom_range(3) < pi), DW'($urandom), ($urandom_range(3) < po),
                         (c % 2 == 0) ? "R2" : "R9");
                end
                while (model_q.size() > 0) step(1'b0, 2'd0, 1'b1, "R2");
                step(1'b0, 2'd0, 1'b0, "R9");
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule